// File: doc/BRIEF.md
# PWM Generator Channel with Per-Event Output Actions

This block is a single pulse-width-modulation channel. A counter runs either down-only (sawtooth) or up then down (triangle). Each cycle it is decoded into up to six events: counter at zero, counter at the load value, and a match against each of two compare values, marked with the direction of counting. Every event has its own two-bit action field. The action can leave the output bit as it is, toggle it, clear it or set it. The output bit therefore follows whatever edge placement the actions describe.

When several events occur in the same cycle, a fixed priority picks the action that applies. The raw events come out as single-cycle pulses, and the counter value is also visible, so that neighbouring logic can use them. While the enable is low, the channel stays idle with its output low.

Top module: `pwmev_gen`

## Requirements
- R1: While `en` is low, and after synchronous reset, `count` is 0, `pwm_out` is 0 and `evt_pulse` is all zeros. Re-enabling starts a fresh period from count 0 counting up.
- R2: `act_cfg` holds six 2-bit action fields: zero in [1:0], load in [3:2], compare A counting up in [5:4], compare A counting down in [7:6], compare B counting up in [9:8], compare B counting down in [11:10]. Code 00 keeps `pwm_out`, 01 inverts it, 10 clears it and 11 sets it.
- R3: With `mode` = 0, the counter at 0 reloads `load` on the next cycle and otherwise decrements, giving the sequence 0, L, L-1, ..., 1, 0 with a period of L+1 cycles.
- R4: With `mode` = 0, only the zero, load, compare-A-down and compare-B-down events occur. The two counting-up compare pulses stay 0.
- R5: With `mode` = 1, the counter runs 0, 1, ..., L, L-1, ..., 1, 0 (period 2L). At 0 it turns upward, and at L or above it turns downward. With L = 0 it stays at 0.
- R6: `evt_pulse` bit order matches the action fields: bit0 zero, bit1 load, bit2 A-up, bit3 A-down, bit4 B-up, bit5 B-down. A compare pulse fires when `count` equals its compare value. Its direction is up at count 0 in mode 1, down at count >= L, and otherwise the current counting direction.
- R7: When a zero or load event coincides with any compare event, only the zero or load action is applied.
- R8: When compare A and compare B events coincide with no zero or load event, only the compare B action is applied.
- R9: When zero and load coincide (L = 0), only the zero action is applied.
- R10: `pwm_out` is registered. It changes one clock after the cycle in which the event is pulsed, and it holds when no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| mode | input | 1 | 0 = count down only, 1 = count up then down |
| load | input | 16 | Period (load) value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_cfg | input | 12 | Six 2-bit action fields |
| pwm_out | output | 1 | PWM output bit |
| evt_pulse | output | 6 | Single-cycle event pulses |
| count | output | 16 | Current counter value |

## Verification
The hardest situations to reach are the coincidences, where several events land on one counter value at once. These arise when a compare value equals 0 or the load value at a turning point, when both compare values are equal, and when the load is 0 so that zero and load meet. The random stimulus draws compare values from the range 0 to load+1 and makes the two compare values equal a quarter of the time. Directed runs also pin these cases down, using actions that disagree, so that only the winning action leaves the expected level.

// File: rtl/pwmev_pkg.sv
package pwmev_pkg;

    localparam int EVT_N   = 6;
    localparam int ACT_FW  = 2;
    localparam int ACT_W   = EVT_N * ACT_FW;

    typedef enum logic [ACT_FW-1:0] {
        ACT_KEEP   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    // first member is most significant
    typedef struct packed {
        logic cb_dn;
        logic cb_up;
        logic ca_dn;
        logic ca_up;
        logic at_load;
        logic at_zero;
    } evt_t;

    typedef struct packed {
        act_e cb_dn;
        act_e cb_up;
        act_e ca_dn;
        act_e ca_up;
        act_e at_load;
        act_e at_zero;
    } act_word_t;

    function automatic logic apply_act(input act_e a, input logic cur);
        logic r;
        case (a)
            ACT_TOGGLE: r = ~cur;
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwmev_counter.sv
module pwmev_counter
    import pwmev_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode,
    input  logic [CNT_W-1:0] load,
    output logic [CNT_W-1:0] cnt,
    output logic             dir_up
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             up_q, up_d;
    logic             at_zero, at_top;

    always_comb begin
        at_zero = (cnt_q == '0);
        at_top  = (cnt_q >= load);
        dir_up  = mode && (at_zero || (!at_top && up_q));
    end

    always_comb begin
        cnt_d = cnt_q;
        up_d  = up_q;
        if (!en) begin
            cnt_d = '0;
            up_d  = 1'b1;
        end else if (!mode) begin
            cnt_d = at_zero ? load : cnt_q - ONE;
            up_d  = 1'b0;
        end else if (at_zero) begin
            cnt_d = (load == '0) ? '0 : ONE;
            up_d  = 1'b1;
        end else if (at_top) begin
            cnt_d = cnt_q - ONE;
            up_d  = 1'b0;
        end else begin
            cnt_d = up_q ? cnt_q + ONE : cnt_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
        end
    end

    assign cnt = cnt_q;

    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        en && !mode && cnt_q == '0 |=> cnt_q == $past(load)); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        en && !mode && cnt_q != '0 |=> cnt_q == $past(cnt_q) - ONE); // R3
    AST_UD_TURN: assert property (@(posedge clk) disable iff (rst)
        en && mode && cnt_q == load && load != '0 |=> cnt_q == $past(load) - ONE); // R5
    AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0); // R1

endmodule

// File: rtl/pwmev_events.sv
module pwmev_events
    import pwmev_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CMP = 2
) (
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic             dir_up,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_t             evt
);

    logic [CNT_W-1:0] cmp_v [N_CMP];
    logic [N_CMP-1:0] hit;

    assign cmp_v[0] = cmp_a;
    assign cmp_v[1] = cmp_b;

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        assign hit[i] = en && (cnt == cmp_v[i]);
    end

    always_comb begin
        evt         = '0;
        evt.at_zero = en && (cnt == '0);
        evt.at_load = en && (cnt == load);
        evt.ca_up   = hit[0] &&  dir_up;
        evt.ca_dn   = hit[0] && !dir_up;
        evt.cb_up   = hit[1] &&  dir_up;
        evt.cb_dn   = hit[1] && !dir_up;
    end

endmodule

// File: rtl/pwmev_select.sv
module pwmev_select
    import pwmev_pkg::*;
(
    input  evt_t      evt,
    input  act_word_t act,
    output act_e      sel
);

    // fixed order: zero, load, compare B, compare A
    always_comb begin
        if (evt.at_zero)      sel = act.at_zero;
        else if (evt.at_load) sel = act.at_load;
        else if (evt.cb_dn)   sel = act.cb_dn;
        else if (evt.cb_up)   sel = act.cb_up;
        else if (evt.ca_dn)   sel = act.ca_dn;
        else if (evt.ca_up)   sel = act.ca_up;
        else                  sel = ACT_KEEP;
    end

endmodule

// File: rtl/pwmev_gen.sv
module pwmev_gen
    import pwmev_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mode,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [ACT_W-1:0] act_cfg,
    output logic             pwm_out,
    output logic [EVT_N-1:0] evt_pulse,
    output logic [CNT_W-1:0] count
);

    act_word_t        act;
    evt_t             evt;
    act_e             sel;
    logic [CNT_W-1:0] cnt;
    logic             dir_up;
    logic             pwm_q;

    assign act = act_word_t'(act_cfg);

    pwmev_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .mode   (mode),
        .load   (load),
        .cnt    (cnt),
        .dir_up (dir_up)
    );

    pwmev_events #(.CNT_W(CNT_W), .N_CMP(2)) u_evt (
        .en     (en),
        .cnt    (cnt),
        .dir_up (dir_up),
        .load   (load),
        .cmp_a  (cmp_a),
        .cmp_b  (cmp_b),
        .evt    (evt)
    );

    pwmev_select u_sel (
        .evt (evt),
        .act (act),
        .sel (sel)
    );

    always_ff @(posedge clk) begin
        if (rst || !en) pwm_q <= 1'b0;
        else            pwm_q <= apply_act(sel, pwm_q);
    end

    assign pwm_out   = pwm_q;
    assign evt_pulse = evt;
    assign count     = cnt;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pwm_out); // R1
    AST_NO_UP_IN_DOWN: assert property (@(posedge clk) disable iff (rst)
        !mode |-> !(evt_pulse[2] || evt_pulse[4])); // R4
    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (rst)
        en && evt_pulse[0] && act_cfg[1:0] == 2'b11 |=> pwm_out); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        en && evt_pulse[1] && !evt_pulse[0] && act_cfg[3:2] == 2'b10 |=> !pwm_out); // R7
    AST_B_OVER_A: assert property (@(posedge clk) disable iff (rst)
        en && evt_pulse[5] && evt_pulse[3] && evt_pulse[1:0] == 2'b00
        && act_cfg[11:10] == 2'b11 |=> pwm_out); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        en && evt_pulse == '0 |=> $stable(pwm_out)); // R10

endmodule

// File: tb/sim_pwmev_gen.sv
module sim_pwmev_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        mode = 1'b0;
    logic [15:0] ld = '0, ca = '0, cb = '0;
    logic [11:0] act = '0;
    logic        pwm;
    logic [5:0]  evp;
    logic [15:0] cnt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference state
    logic [15:0] m_cnt = '0;
    logic        m_up  = 1'b1;
    logic        m_pwm = 1'b0;

    always #10 clk = ~clk;

    pwmev_gen u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .load(ld),
        .cmp_a(ca), .cmp_b(cb), .act_cfg(act),
        .pwm_out(pwm), .evt_pulse(evp), .count(cnt)
    );

    function automatic logic ref_dir();
        return mode && (m_cnt == 0 || (!(m_cnt >= ld) && m_up));
    endfunction

    function automatic logic [5:0] ref_evt();
        logic z, l, a, b, u;
        z = en && m_cnt == 0;
        l = en && m_cnt == ld;
        a = en && m_cnt == ca;
        b = en && m_cnt == cb;
        u = ref_dir();
        return {b && !u, b && u, a && !u, a && u, l, z};
    endfunction

    function automatic logic ref_next_pwm(input logic [5:0] e);
        logic [1:0] code;
        if (!en) return 1'b0;
        if (e[0])      code = act[1:0];
        else if (e[1]) code = act[3:2];
        else if (e[5]) code = act[11:10];
        else if (e[4]) code = act[9:8];
        else if (e[3]) code = act[7:6];
        else if (e[2]) code = act[5:4];
        else           code = 2'b00;
        case (code)
            2'b01:   return ~m_pwm;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return m_pwm;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // compare this cycle, then advance the reference over the next edge
    task automatic step(input string tag);
        logic [5:0]  e;
        logic [15:0] nc;
        logic        nu, np;
        #1;
        e = ref_evt();
        chk(tag, "count", 32'(cnt), 32'(m_cnt));
        chk(tag, "evt", 32'(evp), 32'(e));
        chk(tag, "pwm", 32'(pwm), 32'(m_pwm));
        np = ref_next_pwm(e);
        nu = m_up;
        if (!en) begin
            nc = 0; nu = 1'b1;
        end else if (!mode) begin
            nc = (m_cnt == 0) ? ld : m_cnt - 16'd1; nu = 1'b0;
        end else if (m_cnt == 0) begin
            nc = (ld == 0) ? 16'd0 : 16'd1; nu = 1'b1;
        end else if (m_cnt >= ld) begin
            nc = m_cnt - 16'd1; nu = 1'b0;
        end else begin
            nc = m_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
        end
        @(negedge clk);
        m_cnt = nc; m_up = nu; m_pwm = np;
    endtask

    task automatic setup(input logic m, input logic [15:0] l, input logic [15:0] a,
                         input logic [15:0] b, input logic [11:0] ac);
        en = 1'b0;
        step("R1");
        step("R1");
        mode = m; ld = l; ca = a; cb = b; act = ac;
        en = 1'b1;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual running expected finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1", "count", 32'(cnt), 0);
        chk("R1", "pwm", 32'(pwm), 0);
        chk("R1", "evt", 32'(evp), 0);
        rst = 1'b0;
        @(negedge clk);
        run(3, "R1");

        // R3: sawtooth, zero sets, A-down clears, B-down toggles
        setup(1'b0, 16'd5, 16'd3, 16'd1, {2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11});
        run(14, "R3");
        // R4: only up-counting actions programmed in down mode
        setup(1'b0, 16'd7, 16'd4, 16'd2, {2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 2'b00});
        run(20, "R4");
        // R5: triangle, A-up sets, A-down clears
        setup(1'b1, 16'd6, 16'd2, 16'd4, {2'b00, 2'b00, 2'b10, 2'b11, 2'b00, 2'b00});
        run(30, "R5");
        // R6: distinct compare directions, toggles on each event
        setup(1'b1, 16'd9, 16'd3, 16'd7, 12'b01_01_01_01_00_00);
        run(40, "R6");
        // R7: compares on the turning points with opposing actions
        setup(1'b1, 16'd5, 16'd0, 16'd5, {2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b10});
        run(24, "R7");
        setup(1'b0, 16'd4, 16'd4, 16'd0, {2'b11, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11});
        run(15, "R7");
        // R8: equal compare values, B wins
        setup(1'b1, 16'd8, 16'd3, 16'd3, {2'b11, 2'b10, 2'b10, 2'b11, 2'b00, 2'b00});
        run(36, "R8");
        setup(1'b0, 16'd6, 16'd2, 16'd2, {2'b10, 2'b00, 2'b11, 2'b00, 2'b00, 2'b01});
        run(20, "R8");
        // R9: load 0, zero beats load
        setup(1'b1, 16'd0, 16'd0, 16'd0, {2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11});
        run(6, "R9");
        setup(1'b0, 16'd0, 16'd5, 16'd5, {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10});
        run(6, "R9");
        // R10: quiet cycles hold a set level
        setup(1'b1, 16'd12, 16'd20, 16'd20, {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11});
        run(30, "R10");
        // R1: disable mid-run, then resume
        en = 1'b0;
        run(3, "R1");
        en = 1'b1;
        run(10, "R1");

        // R2: random configurations and mid-run changes
        for (int s = 0; s < 40; s++) begin
            logic [15:0] l, a, b;
            l = 16'($urandom % 24);
            a = 16'($urandom % (32'(l) + 2));
            b = ($urandom % 4 == 0) ? a : 16'($urandom % (32'(l) + 2));
            setup(1'($urandom), l, a, b, 12'($urandom));
            for (int i = 0; i < 40 + int'($urandom % 40); i++) begin
                if ($urandom % 50 == 0) en = ~en;
                if ($urandom % 60 == 0) act = 12'($urandom);
                step("R2");
            end
        end
        finish_up();
    end

endmodule